// File: doc/BRIEF.md
# UART Interrupt Status and Mask Unit

This block gathers the interrupt sources of a serial port and reduces them to one level-sensitive interrupt line. Ten sources feed it. Five are live condition levels from the receive and transmit paths. Five are single-cycle event pulses.

Every source is captured into a sticky status register. A bit stays set until software writes a one to it. A mask register selects which captured bits may raise the interrupt. Software never writes the mask directly. It has one port that sets mask bits and another that clears them, so two drivers can change different bits without a read-modify-write.

Software reaches the block through a word-offset register port. Writes take effect on the clock edge. Reads are combinational.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the mask and the sticky status both read zero and `irq_o` is low.
- R2: A write to offset 0x08 ORs `wdata_i[9:0]` into the mask on the next clock edge.
- R3: A write to offset 0x0C clears every mask bit whose `wdata_i` bit is one. Bits written as zero are unchanged.
- R4: The mask reads back at offset 0x10 in bits 9:0, with all upper bits zero. A write to 0x10 leaves the mask unchanged.
- R5: Status and mask bit positions are: bit0 receive level reached, bit1 receive empty, bit2 receive full, bit3 transmit empty, bit4 transmit full (from `stat_i[4:0]`); bit5 overrun, bit6 framing error, bit7 parity error, bit8 receive timeout, bit9 modem status change (from `evt_i[4:0]`). A source that is high at a clock edge sets its status bit, and the bit then holds until it is cleared.
- R6: A write to offset 0x14 clears every status bit whose `wdata_i` bit is one. Bits written as zero are unchanged. The status reads back at 0x14 in bits 9:0, with all upper bits zero.
- R7: If a source sets a status bit in the same cycle that a write to 0x14 clears it, the bit ends up set.
- R8: `irq_o` is high exactly when the bitwise AND of mask and status is nonzero. It follows the registered state without further delay.
- R9: Reads of any offset other than 0x10 and 0x14, including 0x08, 0x0C and misaligned addresses, return zero. Writes to other offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| stat_i | input | 5 | Live condition levels, status bits 4:0 |
| evt_i | input | 5 | Event pulses, status bits 9:5 |
| irq_o | output | 1 | Level interrupt request |

## Verification
The assertions check several things on every cycle:
- set and clear writes to the mask take effect;
- a direct write to the mask offset changes nothing;
- status bits are captured and held;
- a write-one clear works, and a set wins when it collides with a clear;
- unmapped offsets read zero.

Some behaviour is shown only by the bench's scenarios:
- the bit encoding of each source;
- the reset state;
- the interrupt output under a mix of masks and status values, which the bench compares against its own reference model over long random sequences.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int unsigned OFF_IEN  = 32'h08;
  localparam int unsigned OFF_IDIS = 32'h0C;
  localparam int unsigned OFF_MASK = 32'h10;
  localparam int unsigned OFF_STS  = 32'h14;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_IEN,
    SEL_IDIS,
    SEL_MASK,
    SEL_STS
  } reg_sel_e;
endpackage

// File: rtl/uirq_mask_reg.sv
module uirq_mask_reg #(
  parameter int unsigned W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_en_i,
  input  logic         clr_en_i,
  input  logic [W-1:0] bits_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q <= '0;
    else if (set_en_i) q <= q | bits_i;
    else if (clr_en_i) q <= q & ~bits_i;
  end

  assign q_o = q;

  a_r2_set_or: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_en_i |=> ((q_o & $past(bits_i)) == $past(bits_i)));
  a_r3_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_en_i && !set_en_i) |=> ((q_o & $past(bits_i)) == '0));
endmodule

// File: rtl/uirq_sticky_reg.sv
module uirq_sticky_reg #(
  parameter int unsigned W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q[i] <= 1'b0;
      else if (set_i[i]) q[i] <= 1'b1;  // set beats clear
      else if (clr_i[i]) q[i] <= 1'b0;
    end
  end

  assign q_o = q;

  a_r5_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((q_o & $past(set_i)) == $past(set_i)));
  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(q_o & ~clr_i)) |=> ((q_o & $past(q_o & ~clr_i)) == $past(q_o & ~clr_i)));
  a_r6_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & ~set_i)) |=> ((q_o & $past(clr_i & ~set_i)) == '0));
  a_r7_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & set_i)) |=> ((q_o & $past(clr_i & set_i)) == $past(clr_i & set_i)));
endmodule

// File: rtl/uirq_rd_mux.sv
module uirq_rd_mux
  import uart_irq_pkg::*;
#(
  parameter int unsigned W      = 10,
  parameter int unsigned DATA_W = 32
) (
  input  reg_sel_e          sel_i,
  input  logic [W-1:0]      mask_i,
  input  logic [W-1:0]      sts_i,
  output logic [DATA_W-1:0] rdata_o
);
  always_comb begin
    rdata_o = '0;
    unique case (sel_i)
      SEL_MASK: rdata_o[W-1:0] = mask_i;
      SEL_STS:  rdata_o[W-1:0] = sts_i;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned STAT_W = 5,
  parameter int unsigned EVT_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [STAT_W-1:0] stat_i,
  input  logic [EVT_W-1:0]  evt_i,
  output logic              irq_o
);
  localparam int unsigned IRQ_W = STAT_W + EVT_W;

  reg_sel_e   sel;
  logic [IRQ_W-1:0] mask_q, sts_q, sts_clr;

  always_comb begin
    sel = SEL_NONE;
    if      (addr_i == ADDR_W'(OFF_IEN))  sel = SEL_IEN;
    else if (addr_i == ADDR_W'(OFF_IDIS)) sel = SEL_IDIS;
    else if (addr_i == ADDR_W'(OFF_MASK)) sel = SEL_MASK;
    else if (addr_i == ADDR_W'(OFF_STS))  sel = SEL_STS;
  end

  uirq_mask_reg #(.W(IRQ_W)) i_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_en_i(we_i && sel == SEL_IEN),
    .clr_en_i(we_i && sel == SEL_IDIS),
    .bits_i  (wdata_i[IRQ_W-1:0]),
    .q_o     (mask_q)
  );

  assign sts_clr = (we_i && sel == SEL_STS) ? wdata_i[IRQ_W-1:0] : '0;

  uirq_sticky_reg #(.W(IRQ_W)) i_sts (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i ({evt_i, stat_i}),
    .clr_i (sts_clr),
    .q_o   (sts_q)
  );

  uirq_rd_mux #(.W(IRQ_W), .DATA_W(DATA_W)) i_rd (
    .sel_i  (sel),
    .mask_i (mask_q),
    .sts_i  (sts_q),
    .rdata_o(rdata_o)
  );

  assign irq_o = |(mask_q & sts_q);

  a_r4_mask_ro: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(OFF_MASK)) |=> $stable(mask_q));
  a_r9_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i != ADDR_W'(OFF_MASK) && addr_i != ADDR_W'(OFF_STS)) |-> (rdata_o == '0));
endmodule

// File: tb/test_uart_irq_ctrl.sv
module test_uart_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [4:0]  stat = '0;
  logic [4:0]  evt = '0;
  logic        irq;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  logic [9:0]  m_mask = '0;
  logic [9:0]  m_sts = '0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  uart_irq_ctrl i_uart_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .stat_i(stat), .evt_i(evt), .irq_o(irq)
  );

  function automatic logic [9:0] nxt_mask(logic [9:0] m, logic w, logic [7:0] a, logic [31:0] d);
    if (w && a == 8'h08) return m | d[9:0];
    if (w && a == 8'h0C) return m & ~d[9:0];
    return m;
  endfunction

  function automatic logic [9:0] nxt_sts(logic [9:0] s, logic w, logic [7:0] a, logic [31:0] d,
                                         logic [4:0] st, logic [4:0] ev);
    logic [9:0] clr;
    clr = (w && a == 8'h14) ? d[9:0] : 10'd0;
    return (s & ~clr) | {ev, st};
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(logic w, logic [7:0] a, logic [31:0] d, logic [4:0] st, logic [4:0] ev);
    @(negedge clk);
    we = w; addr = a; wdata = d; stat = st; evt = ev;
    @(posedge clk);
    m_mask = nxt_mask(m_mask, w, a, d);
    m_sts  = nxt_sts(m_sts, w, a, d, st, ev);
  endtask

  task automatic check_regs(string tag);
    @(negedge clk);
    we = 1'b0; stat = '0; evt = '0;
    addr = 8'h10; #2;
    chk(rdata == {22'd0, m_mask}, {tag, " R4 mask read"}, rdata, {22'd0, m_mask});
    addr = 8'h14; #2;
    chk(rdata == {22'd0, m_sts}, {tag, " R6 status read"}, rdata, {22'd0, m_sts});
    chk(irq == |(m_mask & m_sts), {tag, " R8 irq"}, {31'd0, irq}, {31'd0, |(m_mask & m_sts)});
  endtask

  task automatic check_zero(logic [7:0] a);
    @(negedge clk);
    we = 1'b0; addr = a; #2;
    chk(rdata == '0, "R9 unmapped read", rdata, '0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    check_regs("R1 reset");

    // R2 enable writes accumulate
    step(1, 8'h08, 32'h0000_0011, '0, '0);
    step(1, 8'h08, 32'hFFFF_FC02, '0, '0);
    check_regs("R2 enable");
    // R3 disable clears only ones
    step(1, 8'h0C, 32'h0000_0001, '0, '0);
    check_regs("R3 disable");
    // R4 direct mask write ignored
    step(1, 8'h10, 32'h0000_03FF, '0, '0);
    check_regs("R4 mask write");
    // R5 each source position
    step(0, 8'h00, '0, 5'b00001, '0);
    check_regs("R5 stat bit0");
    step(0, 8'h00, '0, '0, 5'b10000);
    check_regs("R5 evt bit9");
    step(1, 8'h08, 32'h0000_0200, '0, '0);
    check_regs("R8 irq from bit9");
    // R6 partial clear
    step(1, 8'h14, 32'h0000_0200, '0, '0);
    check_regs("R6 clear bit9");
    // R7 collision
    step(1, 8'h14, 32'h0000_03FF, 5'b00100, 5'b00010);
    check_regs("R7 set wins");
    // R9 unmapped
    check_zero(8'h00); check_zero(8'h08); check_zero(8'h0C);
    check_zero(8'h11); check_zero(8'h18); check_zero(8'hFC);
    step(1, 8'h18, 32'hFFFF_FFFF, '0, '0);
    check_regs("R9 unmapped write");

    for (int i = 0; i < 400; i++) begin
      logic [7:0]  a;
      logic [31:0] d;
      logic [4:0]  st, ev;
      case ($urandom % 6)
        0: a = 8'h08;
        1: a = 8'h0C;
        2: a = 8'h10;
        3, 4: a = 8'h14;
        default: a = 8'($urandom);
      endcase
      d  = $urandom;
      st = ($urandom % 3 == 0) ? 5'($urandom & $urandom) : '0;
      ev = ($urandom % 4 == 0) ? 5'($urandom) : '0;
      step(1'($urandom % 4 != 0), a, d, st, ev);
      if (i % 4 == 3) check_regs("R5 random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule